// File: doc/BRIEF.md
# Sequential Trial-Multiply Unsigned Divider

This block divides one unsigned integer by another and resolves the quotient one bit per clock, starting at the most significant position. In every step it forms a candidate quotient consisting of the bits already settled, the current bit forced to one and all lower bits zero. It multiplies that candidate by the divisor into a full double-width product and keeps the bit only when the product does not exceed the dividend. No shifted-divisor subtraction is involved; the decision rests entirely on the product comparison.

A client raises `start_i` for one cycle while the block is idle, presenting both operands. The block goes busy and runs one decision per quotient bit. It then uses one extra cycle to form the remainder from the final quotient, using the same multiplier. After that it pulses `done_o` together with the registered quotient, remainder and divide-by-zero flag. The results stay on the ports until the next division completes. The operand width and the multiplier structure are parameters. The multiplier is either the native product operator or a generated shift-and-add array.

Top module: `mc_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `dbz_o` are 0, and `quotient_o` and `remainder_o` are all zeros.
- R2: A `start_i` sampled high while `busy_o` is low captures `dividend_i` and `divisor_i`, and `busy_o` is high from the next cycle.
- R3: For a nonzero divisor, `quotient_o` equals the floor of dividend divided by divisor. It is built from the top bit down, and each bit is kept only if the candidate times the divisor is no larger than the dividend.
- R4: The trial product is 2*W bits wide, so operands at the full range (all ones) divide correctly without wraparound.
- R5: `remainder_o` equals the dividend minus `quotient_o` times the divisor. For a nonzero divisor it is smaller than the divisor.
- R6: `done_o` is high for exactly one cycle. It rises W+1 clock edges after the edge that accepted the start, and `busy_o` falls on that same edge.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running division finishes with its original operands and its original timing.
- R8: `quotient_o`, `remainder_o` and `dbz_o` stay unchanged between completions, including while a new division runs.
- R9: A zero divisor yields a quotient of all ones, a remainder equal to the dividend, and `dbz_o` = 1 together with `done_o`. The next division with a nonzero divisor returns `dbz_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled only when idle |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | W | Registered quotient |
| remainder_o | output | W | Registered remainder |
| dbz_o | output | 1 | Divisor was zero in the last division |

## Verification
The bound checker observes every cycle. It checks that `done_o` never lasts two cycles, that results hold still between completions, and that a completion always satisfies quotient times divisor plus remainder equal to the captured dividend, with the remainder below a nonzero divisor. It also checks the all-ones quotient on a zero divisor and, using a cycle counter, the exact start-to-done latency. The directed bench scenarios are needed for everything else: the reset values, the exact quotients at full-range operands, the dropping of a second start mid-run, and the clearing of the zero-divisor flag on the following division.

// File: rtl/mc_div_pkg.sv
package mc_div_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } div_state_e;

   localparam int MUL_NATIVE    = 0;
   localparam int MUL_SHIFT_ADD = 1;
endpackage

// File: rtl/mc_div_mul.sv
module mc_div_mul #(
   parameter int W        = 32,
   parameter int MUL_IMPL = mc_div_pkg::MUL_NATIVE
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [2*W-1:0] p_o
);
   localparam int PW = 2 * W;

   if (MUL_IMPL == mc_div_pkg::MUL_NATIVE) begin : g_native
      assign p_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
   end else begin : g_shift_add
      logic [PW-1:0] pp [W];
      for (genvar gi = 0; gi < W; gi++) begin : g_pp
         assign pp[gi] = b_i[gi] ? ({{W{1'b0}}, a_i} << gi) : '0;
      end
      always_comb begin
         p_o = '0;
         for (int k = 0; k < W; k++) begin
            p_o = p_o + pp[k];
         end
      end
   end
endmodule

// File: rtl/mc_div_ctrl.sv
module mc_div_ctrl #(
   parameter int W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   output logic                 accept_o,
   output logic                 run_o,
   output logic                 fin_o,
   output logic                 busy_o,
   output logic [$clog2(W)-1:0] idx_o
);
   import mc_div_pkg::*;
   localparam int IW = $clog2(W);

   div_state_e      state_q, state_d;
   logic [IW-1:0]   idx_q, idx_d;

   assign accept_o = start_i && (state_q == ST_IDLE);
   assign run_o    = (state_q == ST_RUN);
   assign fin_o    = (state_q == ST_FIN);
   assign busy_o   = (state_q != ST_IDLE);
   assign idx_o    = idx_q;

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            state_d = ST_RUN;
            idx_d   = IW'(W - 1);
         end
         ST_RUN: begin
            if (idx_q == '0) state_d = ST_FIN;
            else             idx_d   = idx_q - 1'b1;
         end
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
      end
   end
endmodule

// File: rtl/mc_div_qbit.sv
module mc_div_qbit #(
   parameter int W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_i,
   input  logic                 run_i,
   input  logic [$clog2(W)-1:0] idx_i,
   input  logic [W-1:0]         dividend_i,
   input  logic [2*W-1:0]       prod_i,
   output logic [W-1:0]         mul_op_o,
   output logic [W-1:0]         cand_o
);
   logic [W-1:0] cand_q;
   logic [W-1:0] bit_mask;
   logic [W-1:0] trial;
   logic         keep;

   assign bit_mask = W'(1) << idx_i;
   assign trial    = cand_q | bit_mask;
   assign keep     = (prod_i <= {{W{1'b0}}, dividend_i});
   assign mul_op_o = run_i ? trial : cand_q;
   assign cand_o   = cand_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= '0;
      end else if (clear_i) begin
         cand_q <= '0;
      end else if (run_i && keep) begin
         cand_q <= trial;
      end
   end
endmodule

// File: rtl/mc_divider.sv
module mc_divider #(
   parameter int W        = 32,
   parameter int MUL_IMPL = mc_div_pkg::MUL_NATIVE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quotient_o,
   output logic [W-1:0] remainder_o,
   output logic         dbz_o
);
   localparam int IW = $clog2(W);
   localparam int PW = 2 * W;

   if (W < 2) begin : g_bad_width
      $error("mc_divider: W must be at least 2");
   end
   if (MUL_IMPL != mc_div_pkg::MUL_NATIVE && MUL_IMPL != mc_div_pkg::MUL_SHIFT_ADD) begin : g_bad_mul
      $error("mc_divider: MUL_IMPL selects an unknown multiplier");
   end

   logic          accept, run, fin;
   logic [IW-1:0] idx;
   logic [W-1:0]  dividend_q, divisor_q;
   logic [W-1:0]  mul_op, cand;
   logic [PW-1:0] prod;

   mc_div_ctrl #(.W(W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .run_o    (run),
      .fin_o    (fin),
      .busy_o   (busy_o),
      .idx_o    (idx)
   );

   mc_div_qbit #(.W(W)) u_qbit (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (accept),
      .run_i      (run),
      .idx_i      (idx),
      .dividend_i (dividend_q),
      .prod_i     (prod),
      .mul_op_o   (mul_op),
      .cand_o     (cand)
   );

   mc_div_mul #(.W(W), .MUL_IMPL(MUL_IMPL)) u_mul (
      .a_i (mul_op),
      .b_i (divisor_q),
      .p_o (prod)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dividend_q <= '0;
         divisor_q  <= '0;
      end else if (accept) begin
         dividend_q <= dividend_i;
         divisor_q  <= divisor_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         quotient_o  <= '0;
         remainder_o <= '0;
         dbz_o       <= 1'b0;
      end else begin
         done_o <= fin;
         if (fin) begin
            quotient_o  <= cand;
            remainder_o <= dividend_q - prod[W-1:0];
            dbz_o       <= (divisor_q == '0);
         end
      end
   end
endmodule

// File: rtl/mc_divider_chk.sv
module mc_divider_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] quotient_o,
   input logic [W-1:0] remainder_o,
   input logic         dbz_o,
   input logic [W-1:0] dividend_q,
   input logic [W-1:0] divisor_q
);
   logic [31:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cyc <= '0;
      else if (start_i && !busy_o) cyc <= 32'd1;
      else if (busy_o)            cyc <= cyc + 32'd1;
   end

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cyc == 32'(W + 2)) && !busy_o);

   p_hold_q_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(quotient_o) && $stable(remainder_o) && $stable(dbz_o));

   p_identity_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ({{W{1'b0}}, quotient_o} * {{W{1'b0}}, divisor_q}
                  + {{W{1'b0}}, remainder_o}) == {{W{1'b0}}, dividend_q});

   p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && divisor_q != '0) |-> (remainder_o < divisor_q) && !dbz_o);

   p_zero_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && dbz_o) |-> (&quotient_o) && (remainder_o == dividend_q));

   p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o && cyc < 32'(W + 1)) |=> busy_o);
endmodule

bind mc_divider mc_divider_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .quotient_o  (quotient_o),
   .remainder_o (remainder_o),
   .dbz_o       (dbz_o),
   .dividend_q  (dividend_q),
   .divisor_q   (divisor_q)
);

// File: tb/tb_mc_divider.sv
module tb_mc_divider;
   localparam int W        = 32;
   localparam int CLK_PER  = 10;
   localparam int WATCHDOG = 20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] dividend_i = '0;
   logic [W-1:0] divisor_i = '0;
   logic         busy_o, done_o, dbz_o;
   logic [W-1:0] quotient_o, remainder_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   mc_divider #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .dividend_i(dividend_i), .divisor_i(divisor_i),
      .busy_o(busy_o), .done_o(done_o), .quotient_o(quotient_o),
      .remainder_o(remainder_o), .dbz_o(dbz_o)
   );

   always #(CLK_PER/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Runs one division; extra_start pulses a second start at the given busy cycle.
   task automatic run_div(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                          input int extra_start);
      logic [W-1:0] eq, er;
      int n;
      eq = (b == 0) ? '1 : a / b;
      er = (b == 0) ? a : a % b;
      @(negedge clk);
      dividend_i = a; divisor_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      dividend_i = ~a; divisor_i = b + 1;
      chk({tag, " R2 busy"}, busy_o, 1);
      n = 1;
      while (!done_o) begin
         if (n == extra_start) start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         n++;
         if (n > 3 * W) break;
      end
      // done visible W+1 edges after the accepting edge: W+2 negedges after drive
      chk({tag, " R6 latency"}, n, W + 2);
      chk({tag, " R6 busy low"}, busy_o, 0);
      chk({tag, " R3 quotient"}, quotient_o, eq);
      chk({tag, " R5 remainder"}, remainder_o, er);
      chk({tag, " R9 dbz"}, dbz_o, (b == 0));
      @(negedge clk);
      chk({tag, " R6 pulse"}, done_o, 0);
      chk({tag, " R8 hold"}, {quotient_o, remainder_o}, {eq, er});
      chk({tag, " R7 idle"}, busy_o, 0);
   endtask

   task automatic t_reset();
      chk("R1 busy", busy_o, 0);
      chk("R1 done", done_o, 0);
      chk("R1 dbz", dbz_o, 0);
      chk("R1 quotient", quotient_o, 0);
      chk("R1 remainder", remainder_o, 0);
   endtask

   task automatic t_hold_during_run();
      // results of the previous division (100/7) must stay while a new one runs
      @(negedge clk);
      dividend_i = 32'd1000; divisor_i = 32'd3; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8 quotient mid-run", quotient_o, 32'd14);
      chk("R8 remainder mid-run", remainder_o, 32'd2);
      while (!done_o) @(negedge clk);
      chk("R3 quotient 1000/3", quotient_o, 32'd333);
      chk("R5 remainder 1000/3", remainder_o, 32'd1);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_div("R3 basic", 32'd100, 32'd7, 0);
      t_hold_during_run();
      run_div("R3 exact", 32'd144, 32'd12, 0);
      run_div("R3 small-big", 32'd5, 32'd9, 0);
      run_div("R4 max/1", 32'hFFFF_FFFF, 32'd1, 0);
      run_div("R4 max/max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
      run_div("R4 max/2", 32'hFFFF_FFFF, 32'd2, 0);
      run_div("R4 big", 32'hDEAD_BEEF, 32'h0001_0003, 0);
      run_div("R9 zero div", 32'h1234_5678, 32'd0, 0);
      run_div("R9 after zero", 32'd77, 32'd10, 0);
      run_div("R7 restart ignored", 32'h0F0F_0F0F, 32'd255, 6);
      run_div("R7 late restart", 32'd999, 32'd4, W);
      run_div("R5 zero dividend", 32'd0, 32'd13, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule